// File: doc/BRIEF.md
# Direct Sample Mover

This block moves captured samples from one of several input FIFOs directly into an output FIFO. No external memory sits in the path. It waits until the selected input FIFO reports that it is at least half full. It then runs a burst of reads of fixed length, one sample per cycle. It packs each pair of samples into one output word and writes the word into the output FIFO.

The output FIFO is allowed to run dry between host bursts, and that case is not an error. If the output FIFO is full when a packed word is ready, the word is dropped. The drop is recorded in a small status register that software reads and clears.

Bring this block out of reset before the output FIFO is reset and before the front end is started. The block is then idle and waiting when the first samples arrive.

Top module: `dxf_direct_mover`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_rd` is all zero, `out_wr` is low and `stat` is zero.
- R2: A burst starts only in a cycle where `en` is high and the half-full flag of the channel named by `chan_sel` is high. While that flag stays low, no input read is issued.
- R3: A started burst pops exactly BURST_LEN samples (rounded up to an even count), one per cycle whenever the input FIFO is not empty. The block then goes back to checking the half-full flag.
- R4: The first sample of a pair goes in `out_data[SAMPLE_W-1:0]` and the second in `out_data[2*SAMPLE_W-1:SAMPLE_W]`. `out_wr` pulses for one cycle, one cycle after the second sample is read, so two writes are never back to back.
- R5: The channel is latched when a burst starts. Only that channel's bit of `in_rd` is raised, so at most one bit of `in_rd` is high in any cycle.
- R6: If `out_full` is high in the cycle where the second sample of a pair is read, no write occurs for that pair and `stat[0]` (loss flag) is set.
- R7: `stat[0]` and `stat[1]` are sticky. Bit 1 (repeat flag) is set by a loss while bit 0 is already set. A cycle with `stat_clr` high clears bit 0 where `stat_clr_mask[0]` is 1 and bit 1 where `stat_clr_mask[1]` is 1. A loss in the same cycle wins over the clear.
- R8: `stat[2 +: CNT_W]` counts lost words, holds at its all-ones maximum, and is cleared together with bit 0.
- R9: When `en` falls while a half word is held, the block reads the partner sample, writes the word and goes idle. When `en` falls on a word boundary, it goes idle at once with no further read.
- R10: Transfers that meet a non-full output FIFO, including one that has run empty, leave `stat` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Transfer enable |
| chan_sel | input | CH_W | Channel to drain |
| in_half | input | NUM_CH | Half-full flag of each input FIFO |
| in_empty | input | NUM_CH | Empty flag of each input FIFO |
| in_data | input | NUM_CH*SAMPLE_W | Head sample of each input FIFO (show-ahead) |
| in_rd | output | NUM_CH | Pop strobe for each input FIFO |
| out_full | input | 1 | Output FIFO full |
| out_wr | output | 1 | Output FIFO write strobe |
| out_data | output | 2*SAMPLE_W | Packed sample pair |
| stat_clr | input | 1 | Status clear strobe |
| stat_clr_mask | input | 2 | Write-one-to-clear mask for status bits 1:0 |
| stat | output | 2+CNT_W | Loss flag, repeat flag, loss count |

## Verification
The assertions assume that the input FIFOs behave as show-ahead queues: a pop returns the current head, and the empty flag is honest. They also assume that `out_full` is a level the output FIFO holds for at least a whole cycle. The bench models each input FIFO as a fill count minus a pop count. It derives half-full and empty from that difference and presents a head value that encodes the channel and the sample index. Every flag therefore stays consistent with what the block has actually popped. The bench only ever raises `out_full` for whole scenarios, and changes all inputs on the falling edge.

// File: rtl/dxf_pkg.sv
package dxf_pkg;

    typedef enum logic {
        MV_IDLE  = 1'b0,
        MV_BURST = 1'b1
    } mv_state_e;

    function automatic int even_up(input int n);
        return n + (n % 2);
    endfunction

endpackage

// File: rtl/dxf_burst_ctl.sv
module dxf_burst_ctl
    import dxf_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int BURST_LEN = 8,
    parameter int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic [NUM_CH-1:0] in_half,
    input  logic [NUM_CH-1:0] in_empty,
    input  logic              hold,
    output logic              rd_go,
    output logic [CH_W-1:0]   rd_ch,
    output logic              busy,
    output logic              hf_sel
);
    localparam int LEN_EVEN = even_up(BURST_LEN);
    localparam int LEN_W    = $clog2(LEN_EVEN + 1);

    typedef struct packed {
        mv_state_e       state;
        logic [CH_W-1:0] ch;
        logic [LEN_W-1:0] left;
    } ctl_s;

    ctl_s s_d, s_q;

    always_comb begin
        hf_sel = (int'(chan_sel) < NUM_CH) ? in_half[chan_sel] : 1'b0;
    end

    always_comb begin
        s_d   = s_q;
        rd_go = 1'b0;
        case (s_q.state)
            MV_IDLE: begin
                if (en && hf_sel) begin
                    s_d.state = MV_BURST;
                    s_d.ch    = chan_sel;
                    s_d.left  = LEN_W'(LEN_EVEN);
                end
            end
            MV_BURST: begin
                rd_go = !in_empty[s_q.ch] && (en || hold);
                if (rd_go) begin
                    s_d.left = s_q.left - 1'b1;
                    if (s_q.left == LEN_W'(1)) begin
                        s_d.state = MV_IDLE;
                    end
                end else if (!en && !hold) begin
                    s_d.state = MV_IDLE;
                end
            end
            default: s_d.state = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state <= MV_IDLE;
            s_q.ch    <= '0;
            s_q.left  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_ch = s_q.ch;
    assign busy  = (s_q.state == MV_BURST);

endmodule

// File: rtl/dxf_pair_pack.sv
module dxf_pair_pack #(
    parameter int SAMPLE_W = 16,
    parameter int WORD_W   = 2 * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_go,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                out_full,
    output logic                hold,
    output logic                lost,
    output logic                out_wr,
    output logic [WORD_W-1:0]   out_data
);
    typedef struct packed {
        logic                hold;
        logic [SAMPLE_W-1:0] lo;
        logic                wr;
        logic [WORD_W-1:0]   word;
    } pk_s;

    pk_s p_d, p_q;

    always_comb begin
        p_d    = p_q;
        p_d.wr = 1'b0;
        lost   = 1'b0;
        if (rd_go) begin
            if (!p_q.hold) begin
                p_d.hold = 1'b1;
                p_d.lo   = sample;
            end else begin
                p_d.hold = 1'b0;
                if (out_full) begin
                    lost = 1'b1;
                end else begin
                    p_d.wr   = 1'b1;
                    p_d.word = {sample, p_q.lo};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q.hold <= 1'b0;
            p_q.lo   <= '0;
            p_q.wr   <= 1'b0;
            p_q.word <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign hold     = p_q.hold;
    assign out_wr   = p_q.wr;
    assign out_data = p_q.word;

endmodule

// File: rtl/dxf_loss_status.sv
module dxf_loss_status #(
    parameter int CNT_W  = 8,
    parameter int STAT_W = 2 + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lost,
    input  logic              stat_clr,
    input  logic [1:0]        stat_clr_mask,
    output logic [STAT_W-1:0] stat
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rep;
        logic             ovf;
    } st_s;

    st_s t_d, t_q;
    logic             clr_lo;
    logic             clr_hi;
    logic [CNT_W-1:0] cnt_base;

    always_comb begin
        clr_lo   = stat_clr && stat_clr_mask[0];
        clr_hi   = stat_clr && stat_clr_mask[1];
        cnt_base = clr_lo ? '0 : t_q.cnt;
        t_d      = t_q;
        if (clr_lo) begin
            t_d.ovf = 1'b0;
        end
        if (clr_hi) begin
            t_d.rep = 1'b0;
        end
        t_d.cnt = cnt_base;
        if (lost) begin
            t_d.ovf = 1'b1;
            if (t_q.ovf) begin
                t_d.rep = 1'b1;
            end
            if (cnt_base != {CNT_W{1'b1}}) begin
                t_d.cnt = cnt_base + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.cnt <= '0;
            t_q.rep <= 1'b0;
            t_q.ovf <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign stat = t_q;

endmodule

// File: rtl/dxf_direct_mover.sv
module dxf_direct_mover
    import dxf_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int SAMPLE_W  = 16,
    parameter int BURST_LEN = 8,
    parameter int CNT_W     = 8,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int WORD_W   = 2 * SAMPLE_W,
    localparam int STAT_W   = 2 + CNT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic [CH_W-1:0]            chan_sel,
    input  logic [NUM_CH-1:0]          in_half,
    input  logic [NUM_CH-1:0]          in_empty,
    input  logic [NUM_CH*SAMPLE_W-1:0] in_data,
    output logic [NUM_CH-1:0]          in_rd,
    input  logic                       out_full,
    output logic                       out_wr,
    output logic [WORD_W-1:0]          out_data,
    input  logic                       stat_clr,
    input  logic [1:0]                 stat_clr_mask,
    output logic [STAT_W-1:0]          stat
);
    logic                rd_go;
    logic [CH_W-1:0]     rd_ch;
    logic                busy;
    logic                hf_sel;
    logic                hold;
    logic                lost;
    logic [SAMPLE_W-1:0] lane [NUM_CH];
    logic [SAMPLE_W-1:0] sample;

    dxf_burst_ctl #(
        .NUM_CH    (NUM_CH),
        .BURST_LEN (BURST_LEN),
        .CH_W      (CH_W)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .chan_sel (chan_sel),
        .in_half  (in_half),
        .in_empty (in_empty),
        .hold     (hold),
        .rd_go    (rd_go),
        .rd_ch    (rd_ch),
        .busy     (busy),
        .hf_sel   (hf_sel)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        assign lane[g]  = in_data[g*SAMPLE_W +: SAMPLE_W];
        assign in_rd[g] = rd_go && (rd_ch == CH_W'(g));
    end

    assign sample = lane[rd_ch];

    dxf_pair_pack #(
        .SAMPLE_W (SAMPLE_W),
        .WORD_W   (WORD_W)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (rd_go),
        .sample   (sample),
        .out_full (out_full),
        .hold     (hold),
        .lost     (lost),
        .out_wr   (out_wr),
        .out_data (out_data)
    );

    dxf_loss_status #(
        .CNT_W  (CNT_W),
        .STAT_W (STAT_W)
    ) u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .lost          (lost),
        .stat_clr      (stat_clr),
        .stat_clr_mask (stat_clr_mask),
        .stat          (stat)
    );

endmodule

// File: rtl/dxf_direct_mover_chk.sv
module dxf_direct_mover_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [NUM_CH-1:0] in_rd,
    input logic [NUM_CH-1:0] in_empty,
    input logic              out_wr,
    input logic              out_full,
    input logic              stat_clr,
    input logic [1:0]        stat_clr_mask,
    input logic [CNT_W+1:0]  stat,
    input logic              busy,
    input logic              hf_sel
);
    p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en && hf_sel));

    p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rd & in_empty) == '0);

    p_no_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |=> !out_wr);

    p_one_channel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_rd));

    p_write_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> $past(!out_full));

    p_loss_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat[0] && !(stat_clr && stat_clr_mask[0])) |-> stat[0]);

    p_repeat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat[1] && !(stat_clr && stat_clr_mask[1])) |-> stat[1]);

    p_count_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[CNT_W+1:2] == {CNT_W{1'b1}}) && !(stat_clr && stat_clr_mask[0])
        |=> stat[CNT_W+1:2] == {CNT_W{1'b1}});

    p_idle_no_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> in_rd == '0);

endmodule

bind dxf_direct_mover dxf_direct_mover_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .in_rd         (in_rd),
    .in_empty      (in_empty),
    .out_wr        (out_wr),
    .out_full      (out_full),
    .stat_clr      (stat_clr),
    .stat_clr_mask (stat_clr_mask),
    .stat          (stat),
    .busy          (busy),
    .hf_sel        (hf_sel)
);

// File: tb/tb_dxf_direct_mover.sv
module tb_dxf_direct_mover;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 2;
    localparam int SW    = 8;
    localparam int BLEN  = 4;
    localparam int CW    = 4;
    localparam int HALF  = 4;
    localparam int WD_CYCLES = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [0:0]        chan_sel = 1'b0;
    logic [NCH-1:0]    in_half;
    logic [NCH-1:0]    in_empty;
    logic [NCH*SW-1:0] in_data;
    logic [NCH-1:0]    in_rd;
    logic              out_full = 1'b0;
    logic              out_wr;
    logic [2*SW-1:0]   out_data;
    logic              stat_clr = 1'b0;
    logic [1:0]        stat_clr_mask = 2'b00;
    logic [CW+1:0]     stat;

    int fill   [NCH];
    int popped [NCH];
    int words  = 0;
    int last_word = 0;
    int exp_ch = 0;
    int checks = 0;
    int errors = 0;
    int s_checks = 0;
    int s_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [SW-1:0] code(input int c, input int idx);
        return SW'(c * 128 + (idx % 128));
    endfunction

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            in_half[c]  = (fill[c] - popped[c]) >= HALF;
            in_empty[c] = (fill[c] - popped[c]) == 0;
            in_data[c*SW +: SW] = code(c, popped[c]);
        end
    end

    dxf_direct_mover #(
        .NUM_CH    (NCH),
        .SAMPLE_W  (SW),
        .BURST_LEN (BLEN),
        .CNT_W     (CW)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .chan_sel      (chan_sel),
        .in_half       (in_half),
        .in_empty      (in_empty),
        .in_data       (in_data),
        .in_rd         (in_rd),
        .out_full      (out_full),
        .out_wr        (out_wr),
        .out_data      (out_data),
        .stat_clr      (stat_clr),
        .stat_clr_mask (stat_clr_mask),
        .stat          (stat)
    );

    initial begin
        for (int c = 0; c < NCH; c++) begin
            fill[c]   = 0;
            popped[c] = 0;
        end
    end

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst_n && in_rd[c]) popped[c] <= popped[c] + 1;
        end
    end

    // R4/R5: every written word holds an even-indexed sample low, its successor high, from the active channel
    always @(posedge clk) begin
        if (rst_n && out_wr) begin
            words     <= words + 1;
            last_word <= int'(out_data);
            s_checks  <= s_checks + 1;
            if (out_data[0] != 1'b0 || out_data[2*SW-1:SW] != out_data[SW-1:0] + 1'b1
                || int'(out_data[SW-1]) != exp_ch) begin
                s_errors <= s_errors + 1;
                $display("FAIL R4 pair layout: actual %h expected pair of channel %0d", out_data, exp_ch);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", errors + s_errors, checks + s_checks);
    endtask

    task automatic pulse_clear(input logic [1:0] m);
        stat_clr = 1'b1;
        stat_clr_mask = m;
        @(negedge clk);
        stat_clr = 1'b0;
        stat_clr_mask = 2'b00;
        @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        idle(4);
        // R1: outputs quiet during reset and just after
        chk("R1 in_rd in reset", int'(in_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 in_rd", int'(in_rd), 0);
        chk("R1 out_wr", int'(out_wr), 0);
        chk("R1 stat", int'(stat), 0);

        // R2: sweep fill levels below half, no read may happen
        en = 1'b1;
        for (int a = 0; a < HALF; a++) begin
            fill[0] = a;
            idle(10);
            chk($sformatf("R2 no pop at level %0d", a), popped[0], 0);
        end

        // R3: level 8 on channel 0 -> two bursts of 4, four words
        fill[0] = 8;
        idle(30);
        chk("R3 popped", popped[0], 8);
        chk("R3 words", words, 4);
        chk("R4 last word", last_word, {code(0, 7), code(0, 6)});
        chk("R10 stat after clean transfer", int'(stat), 0);

        // R5: channel 1 selected while channel 0 also has data
        exp_ch = 1;
        chan_sel = 1'b1;
        fill[1] = 8;
        fill[0] = 16;
        idle(30);
        chk("R5 ch1 popped", popped[1], 8);
        chk("R5 ch0 untouched", popped[0], 8);
        chk("R5 words", words, 8);
        chk("R4 ch1 last word", last_word, {code(1, 7), code(1, 6)});

        // R5: back to channel 0
        en = 1'b0;
        idle(3);
        exp_ch = 0;
        chan_sel = 1'b0;
        en = 1'b1;
        idle(30);
        chk("R5 ch0 drained", popped[0], 16);
        chk("R5 words after ch0", words, 12);

        // R9: drop enable with half a word held
        en = 1'b0;
        fill[0] = 20;
        idle(5);
        chk("R2 disabled no pop", popped[0], 16);
        en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        en = 1'b0;
        idle(10);
        chk("R9 partner read", popped[0], 18);
        chk("R9 word completed", words, 13);
        en = 1'b1;
        idle(10);
        chk("R2 below half after drop", popped[0], 18);
        fill[0] = 22;
        idle(20);
        chk("R3 resumed burst", popped[0], 22);
        chk("R3 words resumed", words, 15);

        // R6/R7/R8: output full, 20 pairs lost
        out_full = 1'b1;
        fill[0] = 62;
        idle(200);
        chk("R6 all read", popped[0], 62);
        chk("R6 no writes", words, 15);
        chk("R6 loss flag", int'(stat[0]), 1);
        chk("R7 repeat flag", int'(stat[1]), 1);
        chk("R8 count saturated", int'(stat[CW+1:2]), 15);

        pulse_clear(2'b10);
        chk("R7 repeat cleared", int'(stat[1]), 0);
        chk("R7 loss kept", int'(stat[0]), 1);
        chk("R8 count kept", int'(stat[CW+1:2]), 15);

        pulse_clear(2'b01);
        chk("R7 loss cleared", int'(stat[0]), 0);
        chk("R8 count cleared", int'(stat[CW+1:2]), 0);

        fill[0] = 66;
        idle(20);
        chk("R8 count two", int'(stat[CW+1:2]), 2);
        chk("R7 repeat again", int'(stat[1]), 1);

        // R10: room again, nothing further recorded
        out_full = 1'b0;
        fill[0] = 70;
        idle(20);
        chk("R10 words", words, 17);
        chk("R10 count unchanged", int'(stat[CW+1:2]), 2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule